// File: doc/BRIEF.md
# Dual Quad-Byte Horizontal Sum Unit

This execution unit handles one instruction pool of a packed-data extension. It adds up all four unsigned bytes of one 32-bit source register, and separately all four bytes of a second source register. Each total is zero-extended to a 16-bit half, and the two halves are packed into a single 32-bit result. A rounding flavour of the instruction adds a fixed bias of 2 to each total before packing.

The surrounding pipeline supplies three things: the instruction word with a valid strobe, and the two register-file read values selected by the source index fields. The unit returns one register write port: an enable, a destination index and data. It also returns a one-cycle reserved-instruction pulse for the undefined minor code of the pool.

Index 0 names the hard-wired zero register. Any read value presented for index 0 is replaced by zero. A destination of 0 suppresses the write. Instruction words whose padding fields are not all zero are dropped without a trap.

Top module: `hsum_exec`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `wr_en` and `rsvd_pulse` are low.
- R2: The unit acts only on a valid word with bits [31:26] = 0x1C and bits [5:0] = 0x1C. Any other word, or minor code 0 in bits [23:22], produces no write and no pulse.
- R3: Minor code 1 is the plain sum. The destination index is bits [9:6], source B is bits [13:10] and source C is bits [17:14]. `wr_data[31:16]` is the byte total of B and `wr_data[15:0]` is the byte total of C.
- R4: Minor code 2 is the rounding sum. It adds 2 to each of the two totals before packing.
- R5: A nonzero value in bits [25:24] or in bits [21:18] of a minor-1 or minor-2 word causes no write and no pulse.
- R6: A destination index of 0 causes no write, so `wr_en` never comes with `wr_idx` = 0.
- R7: A single source index of 0 gives a total of zero for that half, whatever the read data. In the rounding sum that half reads 2.
- R8: When both source indices are 0, the destination is written with all zeros, even in the rounding sum.
- R9: Minor code 3 raises `rsvd_pulse` for one cycle per valid word, with no write, whatever the padding bits hold.
- R10: The largest result half is 1022 (four bytes of 0xFF plus the bias of 2). It is packed without overflow.
- R11: Every result appears exactly one clock after its word is accepted. A new word can be accepted on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| in_insn | input | 32 | Instruction word |
| in_src_b | input | 32 | Register-file read data for the index in bits [13:10] |
| in_src_c | input | 32 | Register-file read data for the index in bits [17:14] |
| wr_en | output | 1 | Register write enable |
| wr_idx | output | 4 | Register write index |
| wr_data | output | 32 | Register write data: B total in [31:16], C total in [15:0] |
| rsvd_pulse | output | 1 | Reserved-instruction indication, one cycle |

## Verification
Every output of this unit comes from a single register stage. The write enable, index, data and the reserved pulse for a word driven in one cycle are therefore due exactly one clock later. The bench drives each word on a falling edge. At the next falling edge it compares all outputs with the value that its behavioural model computed for that word, so each comparison falls one full clock after its stimulus. Because a new word is presented on every cycle, back-to-back words also show that no result leaks into the neighbouring cycle.

// File: rtl/hsum_pkg.sv
package hsum_pkg;

   localparam int INSN_W = 32;
   localparam int IDX_W  = 4;

   // instruction field positions fixed by the encoding
   localparam int F_MAJOR_LSB = 26;
   localparam int F_PADH_LSB  = 24;
   localparam int F_MINOR_LSB = 22;
   localparam int F_PADL_LSB  = 18;
   localparam int F_SRCC_LSB  = 14;
   localparam int F_SRCB_LSB  = 10;
   localparam int F_DST_LSB   = 6;
   localparam int F_FUNC_LSB  = 0;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_SUM  = 2'd1,
      OP_SUMR = 2'd2,
      OP_RSVD = 2'd3
   } hsum_op_e;

   typedef struct packed {
      hsum_op_e         op;
      logic [IDX_W-1:0] dst;
      logic [IDX_W-1:0] src_b;
      logic [IDX_W-1:0] src_c;
      logic             pad_ok;
   } hsum_dec_t;

endpackage

// File: rtl/hsum_decode.sv
module hsum_decode
   import hsum_pkg::*;
#(
   parameter logic [5:0] MAJOR_CODE = 6'h1C,
   parameter logic [5:0] POOL_CODE  = 6'h1C
) (
   input  logic              valid,
   input  logic [INSN_W-1:0] insn,
   output hsum_dec_t         dec
);

   logic in_pool;

   assign in_pool = valid
                    && (insn[F_MAJOR_LSB +: 6] == MAJOR_CODE)
                    && (insn[F_FUNC_LSB +: 6] == POOL_CODE);

   always_comb begin
      dec.op = OP_NONE;
      if (in_pool) begin
         unique case (insn[F_MINOR_LSB +: 2])
            2'd1:    dec.op = OP_SUM;
            2'd2:    dec.op = OP_SUMR;
            2'd3:    dec.op = OP_RSVD;
            default: dec.op = OP_NONE;
         endcase
      end
      dec.dst    = insn[F_DST_LSB  +: IDX_W];
      dec.src_b  = insn[F_SRCB_LSB +: IDX_W];
      dec.src_c  = insn[F_SRCC_LSB +: IDX_W];
      dec.pad_ok = (insn[F_PADH_LSB +: 2] == 2'd0) && (insn[F_PADL_LSB +: 4] == 4'd0);
   end

endmodule

// File: rtl/hsum_reduce.sv
module hsum_reduce #(
   parameter int DATA_W     = 32,
   parameter int LANE_W     = 8,
   parameter int SUM_W      = 10,
   parameter bit ADDER_TREE = 1'b1
) (
   input  logic [DATA_W-1:0] data,
   output logic [SUM_W-1:0]  sum
);

   localparam int LANES  = DATA_W / LANE_W;
   localparam int LEAVES = 1 << $clog2(LANES);

   if (DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("hsum_reduce: DATA_W must be a multiple of LANE_W");
   end
   if (SUM_W < LANE_W + $clog2(LANES)) begin : g_bad_sum
      $error("hsum_reduce: SUM_W too narrow for the lane total");
   end

   generate
      if (ADDER_TREE) begin : g_tree
         logic [SUM_W-1:0] node [2*LEAVES-1];
         for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
            if (l < LANES) begin : g_used
               assign node[LEAVES-1+l] = SUM_W'(data[l*LANE_W +: LANE_W]);
            end else begin : g_pad
               assign node[LEAVES-1+l] = '0;
            end
         end
         for (genvar n = 0; n < LEAVES-1; n++) begin : g_node
            assign node[n] = node[2*n+1] + node[2*n+2];
         end
         assign sum = node[0];
      end else begin : g_chain
         always_comb begin
            sum = '0;
            for (int l = 0; l < LANES; l++) begin
               sum = sum + SUM_W'(data[l*LANE_W +: LANE_W]);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/hsum_exec.sv
module hsum_exec
   import hsum_pkg::*;
#(
   parameter int         XLEN       = 32,
   parameter int         LANE_W     = 8,
   parameter int         BIAS       = 2,
   parameter bit         ADDER_TREE = 1'b1,
   parameter logic [5:0] MAJOR_CODE = 6'h1C,
   parameter logic [5:0] POOL_CODE  = 6'h1C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [INSN_W-1:0] in_insn,
   input  logic [XLEN-1:0]   in_src_b,
   input  logic [XLEN-1:0]   in_src_c,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [XLEN-1:0]   wr_data,
   output logic              rsvd_pulse
);

   localparam int HALF_W  = XLEN / 2;
   localparam int LANES   = XLEN / LANE_W;
   localparam int SUM_W   = LANE_W + $clog2(LANES);
   localparam int SUM_MAX = LANES * ((1 << LANE_W) - 1) + BIAS;

   if (XLEN % LANE_W != 0 || LANES < 2) begin : g_bad_geom
      $error("hsum_exec: XLEN must hold at least two lanes of LANE_W");
   end
   if (SUM_W > HALF_W || SUM_MAX >= (1 << HALF_W)) begin : g_bad_half
      $error("hsum_exec: biased lane total does not fit a result half");
   end

   hsum_dec_t          dec;
   logic               do_write;
   logic               both_zero;
   logic               add_bias;
   logic [XLEN-1:0]    opnd_b, opnd_c;
   logic [SUM_W-1:0]   sum_b, sum_c;
   logic [HALF_W-1:0]  bias_v, half_hi, half_lo;

   hsum_decode #(
      .MAJOR_CODE (MAJOR_CODE),
      .POOL_CODE  (POOL_CODE)
   ) u_decode (
      .valid (in_valid),
      .insn  (in_insn),
      .dec   (dec)
   );

   // index 0 is the zero register: its read data is never used
   assign opnd_b    = (dec.src_b == '0) ? '0 : in_src_b;
   assign opnd_c    = (dec.src_c == '0) ? '0 : in_src_c;
   assign both_zero = (dec.src_b == '0) && (dec.src_c == '0);

   hsum_reduce #(
      .DATA_W (XLEN), .LANE_W (LANE_W), .SUM_W (SUM_W), .ADDER_TREE (ADDER_TREE)
   ) u_sum_b (
      .data (opnd_b),
      .sum  (sum_b)
   );

   hsum_reduce #(
      .DATA_W (XLEN), .LANE_W (LANE_W), .SUM_W (SUM_W), .ADDER_TREE (ADDER_TREE)
   ) u_sum_c (
      .data (opnd_c),
      .sum  (sum_c)
   );

   assign do_write = ((dec.op == OP_SUM) || (dec.op == OP_SUMR)) && dec.pad_ok && (dec.dst != '0);
   assign add_bias = (dec.op == OP_SUMR) && !both_zero;
   assign bias_v   = add_bias ? HALF_W'(BIAS) : '0;
   assign half_hi  = HALF_W'(sum_b) + bias_v;
   assign half_lo  = HALF_W'(sum_c) + bias_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en      <= 1'b0;
         rsvd_pulse <= 1'b0;
         wr_idx     <= '0;
         wr_data    <= '0;
      end else begin
         wr_en      <= do_write;
         rsvd_pulse <= (dec.op == OP_RSVD);
         if (do_write) begin
            wr_idx  <= dec.dst;
            wr_data <= {half_hi, half_lo};
         end
      end
   end

   // ---------------------------------------------------------------- checks
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!wr_en && !rsvd_pulse)); // R11

   AST_PAD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_insn[F_MAJOR_LSB +: 6] == MAJOR_CODE && in_insn[F_FUNC_LSB +: 6] == POOL_CODE
       && in_insn[F_MINOR_LSB +: 2] != 2'd3
       && (in_insn[F_PADH_LSB +: 2] != 2'd0 || in_insn[F_PADL_LSB +: 4] != 4'd0))
      |=> (!wr_en && !rsvd_pulse)); // R5

   AST_NO_ZERO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_idx != '0)); // R6

   AST_BOTH_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_insn[F_MAJOR_LSB +: 6] == MAJOR_CODE && in_insn[F_FUNC_LSB +: 6] == POOL_CODE
       && (in_insn[F_MINOR_LSB +: 2] == 2'd1 || in_insn[F_MINOR_LSB +: 2] == 2'd2)
       && in_insn[F_PADH_LSB +: 2] == 2'd0 && in_insn[F_PADL_LSB +: 4] == 4'd0
       && in_insn[F_DST_LSB +: IDX_W] != '0
       && in_insn[F_SRCB_LSB +: IDX_W] == '0 && in_insn[F_SRCC_LSB +: IDX_W] == '0)
      |=> (wr_en && wr_data == '0)); // R8

   AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      rsvd_pulse |-> (!wr_en && $past(in_valid))); // R9

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_data[XLEN-1:HALF_W] <= HALF_W'(SUM_MAX)
                 && wr_data[HALF_W-1:0] <= HALF_W'(SUM_MAX))); // R10

endmodule

// File: tb/tb_hsum_exec.sv
module tb_hsum_exec;

   localparam int CLK_PERIOD = 10;
   localparam int RAND_CYCLES = 1500;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_insn = '0;
   logic [31:0] in_src_b = '0;
   logic [31:0] in_src_c = '0;
   logic        wr_en;
   logic [3:0]  wr_idx;
   logic [31:0] wr_data;
   logic        rsvd_pulse;

   int checks = 0;
   int errors = 0;

   logic        exp_en = 1'b0;
   logic [3:0]  exp_idx = '0;
   logic [31:0] exp_data = '0;
   logic        exp_rsvd = 1'b0;
   string       exp_tag = "R1";

   hsum_exec dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_insn    (in_insn),
      .in_src_b   (in_src_b),
      .in_src_c   (in_src_c),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .rsvd_pulse (rsvd_pulse)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   function automatic logic [31:0] mk(input int minor, input int padh, input int padl,
                                      input int c, input int b, input int a);
      return {6'h1C, 2'(padh), 2'(minor), 4'(padl), 4'(c), 4'(b), 4'(a), 6'h1C};
   endfunction

   function automatic int bytes_total(input logic [31:0] w);
      int t = 0;
      for (int i = 0; i < 4; i++) t += int'(w[i*8 +: 8]);
      return t;
   endfunction

   // behavioural expectation for one accepted word
   task automatic model(input logic v, input logic [31:0] w, input logic [31:0] b,
                        input logic [31:0] c);
      int minor, ib, ic, ia, tb, tc;
      exp_en = 1'b0;
      exp_rsvd = 1'b0;
      minor = int'(w[23:22]);
      ia = int'(w[9:6]); ib = int'(w[13:10]); ic = int'(w[17:14]);
      if (v && w[31:26] == 6'h1C && w[5:0] == 6'h1C) begin
         if (minor == 3) exp_rsvd = 1'b1;
         else if (minor != 0 && w[25:24] == 0 && w[21:18] == 0 && ia != 0) begin
            exp_en = 1'b1;
            exp_idx = 4'(ia);
            if (ib == 0 && ic == 0) exp_data = '0;
            else begin
               tb = (ib == 0) ? 0 : bytes_total(b);
               tc = (ic == 0) ? 0 : bytes_total(c);
               if (minor == 2) begin tb += 2; tc += 2; end
               exp_data = {16'(tb), 16'(tc)};
            end
         end
      end
   endtask

   task automatic check_out();
      checks++;
      if (wr_en !== exp_en) begin
         errors++;
         $display("FAIL %s wr_en actual %b expected %b", exp_tag, wr_en, exp_en);
      end
      checks++;
      if (rsvd_pulse !== exp_rsvd) begin
         errors++;
         $display("FAIL %s rsvd_pulse actual %b expected %b", exp_tag, rsvd_pulse, exp_rsvd);
      end
      if (exp_en) begin
         checks++;
         if (wr_idx !== exp_idx || wr_data !== exp_data) begin
            errors++;
            $display("FAIL %s write actual idx %0d data %h expected idx %0d data %h",
                     exp_tag, wr_idx, wr_data, exp_idx, exp_data);
         end
      end
   endtask

   task automatic step(input logic v, input logic [31:0] w, input logic [31:0] b,
                       input logic [31:0] c, input string tag);
      @(negedge clk);
      check_out();
      in_valid = v; in_insn = w; in_src_b = b; in_src_c = c;
      model(v, w, b, c);
      exp_tag = tag;
   endtask

   initial begin
      // R1: outputs quiet while reset is held, even with a valid word applied
      in_valid = 1'b1;
      in_insn  = mk(1, 0, 0, 2, 3, 4);
      in_src_b = 32'hFFFF_FFFF;
      in_src_c = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      exp_tag = "R1";
      check_out();
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      exp_tag = "R1";

      step(1, mk(1, 0, 0, 5, 3, 7), 32'h0102_0304, 32'hFFFF_FFFF, "R3");
      step(1, mk(2, 0, 0, 5, 3, 7), 32'h0102_0304, 32'hFFFF_FFFF, "R4");
      step(1, mk(2, 0, 0, 1, 2, 15), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10");
      step(1, mk(1, 0, 0, 9, 9, 1), 32'h8080_8080, 32'h0000_00FF, "R3");
      step(1, mk(1, 1, 0, 5, 3, 7), 32'h1111_1111, 32'h2222_2222, "R5");
      step(1, mk(2, 0, 8, 5, 3, 7), 32'h1111_1111, 32'h2222_2222, "R5");
      step(1, mk(1, 0, 0, 5, 3, 0), 32'h1111_1111, 32'h2222_2222, "R6");
      step(1, mk(1, 0, 0, 5, 0, 6), 32'hDEAD_BEEF, 32'h0101_0101, "R7");
      step(1, mk(2, 0, 0, 5, 0, 6), 32'hDEAD_BEEF, 32'h0101_0101, "R7");
      step(1, mk(2, 0, 0, 0, 4, 6), 32'h0A0A_0A0A, 32'hFFFF_FFFF, "R7");
      step(1, mk(2, 0, 0, 0, 0, 6), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8");
      step(1, mk(1, 0, 0, 0, 0, 2), 32'h1234_5678, 32'h1234_5678, "R8");
      step(1, mk(3, 0, 0, 5, 3, 7), 32'h1111_1111, 32'h2222_2222, "R9");
      step(1, mk(3, 3, 15, 5, 3, 7), 32'h1111_1111, 32'h2222_2222, "R9");
      step(0, mk(3, 0, 0, 5, 3, 7), 32'h1111_1111, 32'h2222_2222, "R9");
      step(1, mk(0, 0, 0, 5, 3, 7), 32'h1111_1111, 32'h2222_2222, "R2");
      step(1, mk(1, 0, 0, 5, 3, 7) ^ 32'h0000_0001, 32'h1111_1111, 32'h2222_2222, "R2");
      step(1, mk(1, 0, 0, 5, 3, 7) ^ 32'h0400_0000, 32'h1111_1111, 32'h2222_2222, "R2");
      step(0, mk(1, 0, 0, 5, 3, 7), 32'h1111_1111, 32'h2222_2222, "R11");

      for (int n = 0; n < RAND_CYCLES; n++) begin
         logic [31:0] w;
         w = mk(int'($urandom_range(0, 3)),
                ($urandom_range(0, 7) == 0) ? int'($urandom_range(1, 3)) : 0,
                ($urandom_range(0, 7) == 0) ? int'($urandom_range(1, 15)) : 0,
                ($urandom_range(0, 5) == 0) ? 0 : int'($urandom_range(1, 15)),
                ($urandom_range(0, 5) == 0) ? 0 : int'($urandom_range(1, 15)),
                ($urandom_range(0, 7) == 0) ? 0 : int'($urandom_range(1, 15)));
         if ($urandom_range(0, 15) == 0) w[5:0] = 6'(w[5:0] + 6'($urandom_range(1, 63)));
         step(($urandom_range(0, 5) != 0), w, $urandom, $urandom, "R11");
      end
      step(0, '0, '0, '0, "R11");
      @(negedge clk);
      check_out();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule